// File: doc/BRIEF.md
# Registered Two-Port Bus Transceiver

This block sits between two 16-bit buses, called A and B here. It is split into two 8-bit lanes, and each lane has its own controls. The two lanes can be run apart as two byte-wide transceivers, or driven with the same controls so they act as one 16-bit transceiver.

Each lane holds two storage registers. One captures the A bus and feeds the B side. The other captures the B bus and feeds the A side. Each register has its own rising-edge clock.

An active-low enable and a direction bit put each lane into one of three named modes:

- `MODE_ISOLATE`: neither side drives.
- `MODE_A_TO_B`: the B side drives.
- `MODE_B_TO_A`: the A side drives.

The mode is decoded combinationally from the controls, so there is no sequencing. Any control change is a direct transition between the modes it selects:

- ISOLATE→A_TO_B or ISOLATE→B_TO_A when the enable falls.
- A_TO_B↔B_TO_A when the direction flips.
- A_TO_B→ISOLATE or B_TO_A→ISOLATE when the enable rises.

For each driven side, a per-direction select bit picks one of two sources: the live value on the opposite bus, or the stored register contents. The registers keep capturing in every mode, including isolation.

The bidirectional pins are modelled as three separate signals: an input, an output and an output enable. An outside pad ring or tri-state wrapper combines them into the physical pins. The output data lines always carry the selected source, and the enable signals say when that value is really driven. The source multiplexer includes a consensus term. Because of it, the output does not dip while the select changes if the live and stored values already agree.

Top module: `bus_xcvr16`

## Requirements
- R1: On each rising edge of a lane's A-side capture clock, that lane's A-bus byte is stored in its A-to-B register.
- R2: On each rising edge of a lane's B-side capture clock, that lane's B-bus byte is stored in its B-to-A register.
- R3: While `rst_n` is low, both registers of every lane read zero, without any clock edge being needed.
- R4: With a lane's `oe_n` at 1 (isolation), both of that lane's output enables are 0, whatever the direction bit is.
- R5: With `oe_n` at 0, `dir` = 1 raises only the lane's B-side enable, and `dir` = 0 raises only its A-side enable.
- R6: The B-side data of a lane equals the live A byte when `sel_ab` = 0, and the A-to-B register when `sel_ab` = 1.
- R7: The A-side data of a lane equals the live B byte when `sel_ba` = 0, and the B-to-A register when `sel_ba` = 1.
- R8: Capture into both registers works the same in every mode and for every select setting. Data stored during isolation is the data presented later on a stored-mode read.
- R9: Each lane responds only to its own controls and clocks. Activity in one lane leaves the other lane's outputs and registers unchanged.
- R10: When the live byte and the stored byte of a path are equal, the path output equals that byte for both select values.
- R11: The A-side and B-side enables of a lane are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of all storage registers |
| clk_ab | input | 2 | Per-lane rising-edge capture clock of the A-to-B register |
| clk_ba | input | 2 | Per-lane rising-edge capture clock of the B-to-A register |
| oe_n | input | 2 | Per-lane active-low output enable |
| dir | input | 2 | Per-lane direction, 1 = A drives B, 0 = B drives A |
| sel_ab | input | 2 | Per-lane B-side source, 0 = live A, 1 = stored |
| sel_ba | input | 2 | Per-lane A-side source, 0 = live B, 1 = stored |
| a_in | input | 16 | Value sensed on the A bus |
| a_out | output | 16 | Value offered to the A bus |
| a_oe | output | 2 | Per-lane A-side drive enable |
| b_in | input | 16 | Value sensed on the B bus |
| b_out | output | 16 | Value offered to the B bus |
| b_oe | output | 2 | Per-lane B-side drive enable |

## Verification
The capture assertions assume three things about the inputs:

- The bus inputs stay still across each capture-clock edge.
- A capture clock stays low while reset is held.
- Each capture clock pulses only after the previous captured value has settled.

The bench meets these by changing data only at points with no clock edge. It pulses the lane clocks as short isolated pulses, and it holds them low during both reset phases. The path assertions sample on the capture clocks and assume the selects are steady around those edges. The bench changes a select only between pulses, never during one.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_A_TO_B  = 2'd1,
        MODE_B_TO_A  = 2'd2
    } lane_mode_e;

    function automatic lane_mode_e decode_mode(input logic oe_n, input logic dir);
        if (oe_n)
            return MODE_ISOLATE;
        else if (dir)
            return MODE_A_TO_B;
        else
            return MODE_B_TO_A;
    endfunction

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    // R1/R2: every edge captures, no enable gates the load
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q == $past(d)))
        else $error("capture register missed its input");

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
    parameter int WIDTH = 8
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] out
);

    logic [WIDTH-1:0] sel_vec;

    always_comb begin
        sel_vec = {WIDTH{sel}};
        // consensus term keeps bits steady while sel moves if both inputs agree
        out = (live & ~sel_vec) | (stored & sel_vec) | (live & stored);
    end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             rst_n,
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_data,
    output logic [WIDTH-1:0] b_data,
    output logic             a_drive,
    output logic             b_drive
);

    lane_mode_e       mode;
    logic [WIDTH-1:0] ab_q;
    logic [WIDTH-1:0] ba_q;

    xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_ab (
        .clk   (clk_ab),
        .rst_n (rst_n),
        .d     (a_in),
        .q     (ab_q)
    );

    xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_ba (
        .clk   (clk_ba),
        .rst_n (rst_n),
        .d     (b_in),
        .q     (ba_q)
    );

    xcvr_path_mux #(.WIDTH(WIDTH)) u_mux_to_b (
        .sel    (sel_ab),
        .live   (a_in),
        .stored (ab_q),
        .out    (b_data)
    );

    xcvr_path_mux #(.WIDTH(WIDTH)) u_mux_to_a (
        .sel    (sel_ba),
        .live   (b_in),
        .stored (ba_q),
        .out    (a_data)
    );

    always_comb begin
        mode = decode_mode(oe_n, dir);
    end

    always_comb begin
        a_drive = 1'b0;
        b_drive = 1'b0;
        unique case (mode)
            MODE_ISOLATE: begin
                a_drive = 1'b0;
                b_drive = 1'b0;
            end
            MODE_A_TO_B: b_drive = 1'b1;
            MODE_B_TO_A: a_drive = 1'b1;
            default: begin
                a_drive = 1'b0;
                b_drive = 1'b0;
            end
        endcase
    end

    assert_stored_to_b_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
        sel_ab |-> (b_data == ab_q))
        else $error("B side not fed from stored value");

    assert_live_to_b_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !sel_ab |-> (b_data == a_in))
        else $error("B side not fed from live A");

    assert_stored_to_a_R7: assert property (@(posedge clk_ba) disable iff (!rst_n)
        sel_ba |-> (a_data == ba_q))
        else $error("A side not fed from stored value");

    assert_no_glitch_R10: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (a_in == ab_q) |-> (b_data == a_in))
        else $error("agreeing sources gave different output");

    assert_isolate_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
        oe_n |-> (!a_drive && !b_drive))
        else $error("drive enabled during isolation");

endmodule

// File: rtl/bus_xcvr16.sv
module bus_xcvr16 #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int BUS_W = LANE_W * LANES
) (
    input  logic             rst_n,
    input  logic [LANES-1:0] clk_ab,
    input  logic [LANES-1:0] clk_ba,
    input  logic [LANES-1:0] oe_n,
    input  logic [LANES-1:0] dir,
    input  logic [LANES-1:0] sel_ab,
    input  logic [LANES-1:0] sel_ba,
    input  logic [BUS_W-1:0] a_in,
    output logic [BUS_W-1:0] a_out,
    output logic [LANES-1:0] a_oe,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic [LANES-1:0] b_oe
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xcvr_lane #(.WIDTH(LANE_W)) u_lane (
            .rst_n   (rst_n),
            .clk_ab  (clk_ab[g]),
            .clk_ba  (clk_ba[g]),
            .oe_n    (oe_n[g]),
            .dir     (dir[g]),
            .sel_ab  (sel_ab[g]),
            .sel_ba  (sel_ba[g]),
            .a_in    (a_in[g*LANE_W +: LANE_W]),
            .b_in    (b_in[g*LANE_W +: LANE_W]),
            .a_data  (a_out[g*LANE_W +: LANE_W]),
            .b_data  (b_out[g*LANE_W +: LANE_W]),
            .a_drive (a_oe[g]),
            .b_drive (b_oe[g])
        );

        assert_single_driver_R11: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
            !(a_oe[g] && b_oe[g]))
            else $error("both sides of a lane driving");

        assert_drive_follows_dir_R5: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
            !oe_n[g] |-> (b_oe[g] == dir[g]) && (a_oe[g] == !dir[g]))
            else $error("drive side does not match direction");
    end

endmodule

// File: tb/bus_xcvr16_bench.sv
module bus_xcvr16_bench;

    localparam int LW = 8;
    localparam int NL = 2;
    localparam int BW = LW * NL;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0] clk_ab, clk_ba, oe_n, dir, sel_ab, sel_ba;
    logic [BW-1:0] a_in, b_in, a_out, b_out;
    logic [NL-1:0] a_oe, b_oe;

    logic [LW-1:0] mdl_ab [NL];
    logic [LW-1:0] mdl_ba [NL];

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    bus_xcvr16 #(.LANE_W(LW), .LANES(NL)) u_bus_xcvr16 (
        .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_ab(input int l);
        clk_ab[l] = 1'b1;
        #1;
        clk_ab[l] = 1'b0;
        #1;
        mdl_ab[l] = a_in[l*LW +: LW];
    endtask

    task automatic pulse_ba(input int l);
        clk_ba[l] = 1'b1;
        #1;
        clk_ba[l] = 1'b0;
        #1;
        mdl_ba[l] = b_in[l*LW +: LW];
    endtask

    task automatic check_lane(input int l, input string tag);
        logic [LW-1:0] exp_b, exp_a;
        exp_b = sel_ab[l] ? mdl_ab[l] : a_in[l*LW +: LW];
        exp_a = sel_ba[l] ? mdl_ba[l] : b_in[l*LW +: LW];
        chk({"R6/R9 ", tag}, 32'(b_out[l*LW +: LW]), 32'(exp_b));
        chk({"R7/R9 ", tag}, 32'(a_out[l*LW +: LW]), 32'(exp_a));
        if (oe_n[l]) begin
            chk({"R4 ", tag}, {30'd0, a_oe[l], b_oe[l]}, 32'd0);
        end else begin
            chk({"R5 ", tag}, {30'd0, a_oe[l], b_oe[l]}, {30'd0, !dir[l], dir[l]});
        end
        chk({"R11 ", tag}, 32'(a_oe[l] & b_oe[l]), 32'd0);
    endtask

    task automatic check_stored(input string tag);
        for (int l = 0; l < NL; l++) begin
            chk({"R1/R8 ", tag}, 32'(b_out[l*LW +: LW]), 32'(mdl_ab[l]));
            chk({"R2/R8 ", tag}, 32'(a_out[l*LW +: LW]), 32'(mdl_ba[l]));
        end
    endtask

    initial begin
        rst_n  = 1'b0;
        clk_ab = '0; clk_ba = '0;
        oe_n   = '1; dir = '0;
        sel_ab = '1; sel_ba = '1;
        a_in   = 16'hFFFF; b_in = 16'hFFFF;
        for (int l = 0; l < NL; l++) begin
            mdl_ab[l] = '0;
            mdl_ba[l] = '0;
        end
        repeat (3) @(negedge clk);
        // R3: registers clear while reset is held
        chk("R3 reset b_out", 32'(b_out), 32'd0);
        chk("R3 reset a_out", 32'(a_out), 32'd0);
        chk("R4 reset enables", {28'd0, a_oe, b_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep all control settings of both lanes
        for (int i = 0; i < 256; i++) begin
            logic [15:0] ap, bp;
            @(negedge clk);
            {oe_n[0], dir[0], sel_ab[0], sel_ba[0]} = 4'(i);
            {oe_n[1], dir[1], sel_ab[1], sel_ba[1]} = 4'(i >> 4);
            ap = 16'hA5C3 ^ 16'(i * 16'h1357);
            bp = 16'h3C96 ^ 16'(i * 16'h2468);
            a_in = ap;
            b_in = bp;
            #0.5;
            for (int l = 0; l < NL; l++) begin
                if (((i >> l) & 1) == 1) pulse_ab(l);
                if (((i >> (l + 2)) & 1) == 0) pulse_ba(l);
            end
            a_in = ~ap ^ 16'(i);
            b_in = ~bp;
            #0.5;
            for (int l = 0; l < NL; l++) check_lane(l, $sformatf("combo %0d lane %0d", i, l));
        end

        // R8: capture during isolation, read back later in stored mode
        @(negedge clk);
        oe_n = '1; sel_ab = '1; sel_ba = '1;
        a_in = 16'h1E2D; b_in = 16'h4B5A;
        #0.5;
        for (int l = 0; l < NL; l++) begin
            pulse_ab(l);
            pulse_ba(l);
        end
        a_in = 16'h0000; b_in = 16'hFFFF;
        @(negedge clk);
        oe_n = '0; dir = 2'b01;
        #0.5;
        check_stored("isolation capture read back");

        // R9: pulse only lane 1, lane 0 storage must be untouched
        a_in = 16'h7788; b_in = 16'h9911;
        #0.5;
        pulse_ab(1);
        pulse_ba(1);
        a_in = 16'h0000; b_in = 16'h0000;
        #0.5;
        chk("R9 lane0 ab kept", 32'(b_out[7:0]), 32'h2D);
        chk("R9 lane0 ba kept", 32'(a_out[7:0]), 32'h5A);
        chk("R9 lane1 ab new", 32'(b_out[15:8]), 32'h77);
        chk("R9 lane1 ba new", 32'(a_out[15:8]), 32'h99);

        // R10: agreeing sources give the same output for either select
        @(negedge clk);
        a_in = 16'hC33C; b_in = 16'h6996;
        #0.5;
        for (int l = 0; l < NL; l++) begin
            pulse_ab(l);
            pulse_ba(l);
        end
        for (int s = 0; s < 2; s++) begin
            sel_ab = s[0] ? 2'b11 : 2'b00;
            sel_ba = s[0] ? 2'b00 : 2'b11;
            #0.5;
            chk("R10 equal sources b", 32'(b_out), 32'hC33C);
            chk("R10 equal sources a", 32'(a_out), 32'h6996);
        end

        // R3: asynchronous clear mid-run, no clock edge
        @(negedge clk);
        sel_ab = '1; sel_ba = '1;
        #0.5;
        rst_n = 1'b0;
        #0.5;
        chk("R3 async clear b", 32'(b_out), 32'd0);
        chk("R3 async clear a", 32'(a_out), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule